// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block turns a fast input clock into a slow, adjustable clock that a user design can run from at a rate a person can watch. A free-running binary counter advances on every enabled input-clock cycle, and one of its bits is picked as the slow clock. The bit index is a fixed base offset plus a small select value, so each select step halves the output frequency.

The chosen counter bit passes through an output flop, so the slow clock has no combinational glitches. While the divider is disabled, the counter is held at zero and the output is forced low. With the default settings there are nine usable taps, from counter bit 13 to bit 21. At a 100 MHz input that gives a slow clock from about 6 kHz down to about 20 Hz. A select value that would point above the top counter bit is clamped to the top bit.

Top module: `clk_pow2_divider`

## Requirements
- R1: A synchronous reset, sampled high at a clock edge, clears the counter to zero and drives `slowClk` low after that edge.
- R2: While `divEnable` is low at a clock edge, `slowClk` is low after that edge and the counter is held at zero.
- R3: The tapped counter bit index is TAP_BASE + `tapSel`.
- R4: A select value for which TAP_BASE + `tapSel` exceeds CNT_W-1 uses counter bit CNT_W-1.
- R5: `slowClk` is registered. After an enabled edge it equals the selected bit of the counter value held before that edge.
- R6: On each enabled edge the counter advances by one, starting from zero. After enable rises, `slowClk` first goes high after 2^idx + 1 enabled edges, where idx is the tapped bit index. With a steady select, it then toggles every 2^idx cycles.
- R7: A change of `tapSel` while enabled takes effect at the next edge and does not clear the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| divEnable | input | 1 | Runs the divider when high and forces the output low when low |
| tapSel | input | SEL_W | Tap select; the tapped bit index is TAP_BASE plus this value, clamped |
| slowClk | output | 1 | Registered divided clock |

## Verification
The bench sweeps every select value on a reduced configuration: a 6-bit counter, base offset 1 and a 3-bit select. Both in-range taps and clamped taps are covered, and an arithmetic counter model gives the expected output on every cycle. Long enabled runs show the period and the first rising edge, which tells a wrong tap offset apart from a wrong clamp. Changing the select in the middle of a run separates a design that keeps counting from one that restarts. Disabled windows and a reset in the middle of a run show that the output is forced low and the count restarts from zero.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  typedef struct packed {
    logic clearCnt;
    logic gateOn;
  } divStrobe_t;
endpackage

// File: rtl/clk_div_ctrl.sv
module clk_div_ctrl
  import clk_div_pkg::*;
#(
  parameter int CNT_W    = 22,
  parameter int TAP_BASE = 13,
  parameter int SEL_W    = 4,
  localparam int TAP_W   = $clog2(CNT_W),
  localparam int MAX_TAP = CNT_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             divEnable,
  input  logic [SEL_W-1:0] tapSel,
  output divStrobe_t       strobe,
  output logic [TAP_W-1:0] tapIdx
);
  int unsigned rawIdx;

  always_comb begin
    rawIdx = TAP_BASE + int'(tapSel);
    if (rawIdx > MAX_TAP) tapIdx = TAP_W'(MAX_TAP);
    else                  tapIdx = TAP_W'(rawIdx);
  end

  always_comb begin
    strobe.clearCnt = rst | ~divEnable;
    strobe.gateOn   = divEnable & ~rst;
  end

  // R4: the index never leaves the counter
  p_tap_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    int'(tapIdx) <= MAX_TAP);
  // R3: in-range selects map straight through
  p_tap_offset_r3: assert property (@(posedge clk) disable iff (rst)
    (TAP_BASE + int'(tapSel) <= MAX_TAP) |-> (int'(tapIdx) == TAP_BASE + int'(tapSel)));
endmodule

// File: rtl/clk_div_datapath.sv
module clk_div_datapath
  import clk_div_pkg::*;
#(
  parameter int CNT_W  = 22,
  localparam int TAP_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobe_t       strobe,
  input  logic [TAP_W-1:0] tapIdx,
  output logic             slowClk
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (strobe.clearCnt) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!strobe.gateOn) slowClk <= 1'b0;
    else                slowClk <= cnt[tapIdx];
  end

  // R2: a gated-off cycle leaves the output low and the count at zero
  p_off_when_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe.gateOn |=> (!slowClk && cnt == '0));
  // R6: the count advances by one on each enabled edge
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe.clearCnt |=> cnt == $past(cnt) + 1'b1);
  // R5: the output follows the tapped bit one edge later
  p_registered_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.gateOn |=> slowClk == $past(cnt[tapIdx]));
endmodule

// File: rtl/clk_pow2_divider.sv
module clk_pow2_divider
  import clk_div_pkg::*;
#(
  parameter int CNT_W    = 22,
  parameter int TAP_BASE = 13,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             divEnable,
  input  logic [SEL_W-1:0] tapSel,
  output logic             slowClk
);
  localparam int TAP_W = $clog2(CNT_W);

  divStrobe_t       strobe;
  logic [TAP_W-1:0] tapIdx;

  clk_div_ctrl #(.CNT_W(CNT_W), .TAP_BASE(TAP_BASE), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .divEnable(divEnable), .tapSel(tapSel),
    .strobe(strobe), .tapIdx(tapIdx)
  );

  clk_div_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .tapIdx(tapIdx), .slowClk(slowClk)
  );

  // R1: reset drives the output low
  p_reset_low_r1: assert property (@(posedge clk) rst |=> !slowClk);
endmodule

// File: tb/clk_pow2_divider_tb.sv
module clk_pow2_divider_tb;
  localparam int CW = 6;
  localparam int TB = 1;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic divEnable = 1'b0;
  logic [SW-1:0] tapSel = '0;
  logic slowClk;

  int checks = 0;
  int errors = 0;
  int mcnt = 0;
  logic expOut = 1'b0;

  always #4 clk = ~clk;

  clk_pow2_divider #(.CNT_W(CW), .TAP_BASE(TB), .SEL_W(SW)) u_dut (
    .clk(clk), .rst(rst), .divEnable(divEnable), .tapSel(tapSel), .slowClk(slowClk)
  );

  function automatic int tapOf(input int s);
    int b;
    b = TB + s;
    if (b > CW - 1) b = CW - 1;
    return b;
  endfunction

  task automatic step(input logic r, input logic e, input int s, input string req);
    rst = r; divEnable = e; tapSel = SW'(s);
    if (r)       begin expOut = 1'b0; mcnt = 0; end
    else if (!e) begin expOut = 1'b0; mcnt = 0; end
    else begin
      expOut = mcnt[tapOf(s)];
      mcnt = (mcnt + 1) % (1 << CW);
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (slowClk !== expOut) begin
      errors++;
      $display("FAIL %s sel=%0d actual=%b expected=%b", req, s, slowClk, expOut);
    end
  endtask

  initial begin
    int firstRise;
    #200000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int firstRise;
    @(negedge clk);
    // R1: reset state
    step(1, 1, 3, "R1");
    step(1, 0, 0, "R1");
    // R2: disabled output stays low
    for (int i = 0; i < 10; i++) step(0, 0, i % 8, "R2");
    // R3 R4 R5 R6: full sweep of selects, each from a fresh enable
    for (int s = 0; s < 8; s++) begin
      step(0, 0, s, "R2");
      firstRise = -1;
      for (int i = 0; i < 140; i++) begin
        step(0, 1, s, (s + TB > CW - 1) ? "R4" : "R3_R5");
        if (firstRise < 0 && slowClk) firstRise = i + 1;
      end
      // R6: first rise after 2^idx + 1 enabled edges
      checks++;
      if (firstRise != (1 << tapOf(s)) + 1) begin
        errors++;
        $display("FAIL R6 sel=%0d actual=%0d expected=%0d", s, firstRise, (1 << tapOf(s)) + 1);
      end
    end
    // R7: select changes mid-run keep the count
    step(0, 0, 0, "R2");
    for (int i = 0; i < 200; i++) step(0, 1, (i / 13) % 8, "R7");
    // R2: disable mid-run then resume from zero
    for (int i = 0; i < 5; i++) step(0, 0, 2, "R2");
    for (int i = 0; i < 40; i++) step(0, 1, 1, "R6");
    // R1: reset mid-run
    step(1, 1, 1, "R1");
    for (int i = 0; i < 40; i++) step(0, 1, 0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule